// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block takes 16-bit two's-complement conversion results, presented as a parallel word with a one-cycle valid strobe, and sends them out serially. Each word goes out most significant bit first, next to a bit clock and an active-low frame signal. The bit clock is the master clock divided by two. A phase counter that runs on the master clock sets when each frame starts. In the two standard modes a frame can start once every 128 bit clocks. In the low-rate mode it can start only once every 256 bit clocks.

An active-low output enable controls the port's single drive enable. Raising the enable input in the middle of a word releases the port in the same cycle and drops the rest of that word. An active-low reset keeps the port idle. In direct-clock mode the reset also returns the phase counter to zero, so that several ports can be aligned. In the other modes the phase counter keeps running through reset.

Top module: `frame_serial_port`

## Requirements
- R1: While `rstN` is low, `frameN` is high and no word is sent. Reset also discards any word that is waiting to be sent.
- R2: `sclk` toggles on every master clock edge while `rstN` is high. In direct-clock mode, `sclk` is low while reset is held and rises on the first edge after reset is released.
- R3: `mode` is decoded as 0 = direct clock, 1 = 2x clock generation, 2 = low rate, and 3 = same as 1. In modes 0, 1 and 3 the frame cadence is 256 master clocks. In mode 2 it is 512 master clocks.
- R4: Take phase p to be the number of master edges since the period origin (modulo the cadence). A frame starts at phase 3, where `frameN` falls together with a rising edge of `sclk`. That is one bit clock after the word-start sampling edge at phase 1. `frameN` then stays low for exactly 32 master clocks (phases 3 to 34).
- R5: Bits are sent MSB first. Bit k of the frame (k = 0 is bit 15) is driven during phases 3+2k and 4+2k. It changes only on a rising edge of `sclk` and is stable across the falling edge.
- R6: A word strobed by `wordValid` is held in a one-deep buffer and sent at the next frame start. A newer word overwrites an older one that is still waiting. A word that arrives during a transfer does not disturb that transfer.
- R7: If no word is waiting at a frame start, no frame is sent in that period.
- R8: When `oeN` is high, `outEn` is low in the same cycle. Any transfer in progress is dropped, so `frameN` stays high after the port is re-enabled until the next frame start. A word that is still waiting is kept, and no frame starts while `oeN` is high.
- R9: Reset moves the phase counter back to zero only in mode 0. In the other modes the frame cadence is not shifted by a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset; also aligns the phase counter in direct-clock mode |
| mode | input | 2 | Cadence and clocking mode select |
| oeN | input | 1 | Active-low output enable |
| wordIn | input | 16 | Parallel two's-complement sample |
| wordValid | input | 1 | One-cycle strobe that captures `wordIn` |
| sdo | output | 1 | Serial data, MSB first |
| sclk | output | 1 | Bit clock, master clock divided by two |
| frameN | output | 1 | Active-low frame, low for 16 bit clocks |
| outEn | output | 1 | Drive enable for `sdo`, `sclk` and `frameN` |

## Verification
All expected timing is worked out from a phase count that the bench keeps itself. The count is cleared by a direct-mode reset and taken modulo the mode's cadence. A word strobed in one cycle is visible on the port only at the next phase 3. The bench checks `frameN` at phase 2 and then samples every bit at both halves of its bit clock, at phases 3+2k and 4+2k, on falling master edges. The release of `outEn` is combinational, so it is checked one time step after `oeN` changes, with no clock edge in between. The abort, no-pending, low-rate and reset-alignment cases are checked at the exact phase where a wrong design would start a frame.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_GEN2X   = 2'd1,
    MODE_LOWRATE = 2'd2,
    MODE_GENALT  = 2'd3
  } fsp_mode_e;

  typedef struct packed {
    logic load;
    logic shift;
  } fsp_strobe_t;

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RATIO  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  fsp_mode_e   modeSel,
  input  logic        oeN,
  input  logic        pendValid,
  output fsp_strobe_t strb,
  output logic        bitClk,
  output logic        txActive
);
  localparam int PER_STD = 2 * RATIO;
  localparam int PHASE_W = $clog2(4 * RATIO);
  localparam logic [PHASE_W-1:0] LAST_STD = PHASE_W'(PER_STD - 1);
  localparam logic [PHASE_W-1:0] LAST_LOW = PHASE_W'(2 * PER_STD - 1);
  localparam logic [PHASE_W-1:0] LOAD_PH  = PHASE_W'(2);
  localparam logic [PHASE_W-1:0] END_PH   = PHASE_W'(2 + 2 * WORD_W);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] lastPh;
  logic               busy;

  assign lastPh = (modeSel == MODE_LOWRATE) ? LAST_LOW : LAST_STD;

  always_ff @(posedge clk) begin
    if (!rstN && modeSel == MODE_DIRECT) phase <= '0;
    else if (phase == lastPh)           phase <= '0;
    else                                phase <= phase + 1'b1;
  end

  always_comb begin
    strb.load  = rstN && !oeN && !busy && pendValid && (phase == LOAD_PH);
    strb.shift = busy && !oeN && !phase[0] && (phase != END_PH);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               busy <= 1'b0;
    else if (busy && (oeN || phase == END_PH)) busy <= 1'b0;
    else if (strb.load)                      busy <= 1'b1;
  end

  assign bitClk   = phase[0];
  assign txActive = busy && rstN;
endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  fsp_strobe_t       strb,
  output logic              pendValid,
  output logic              serBit
);
  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN)          pendValid <= 1'b0;
    else if (wordValid) pendValid <= 1'b1;
    else if (strb.load) pendValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wordValid) holdWord <= wordIn;
  end

  always_ff @(posedge clk) begin
    if (strb.load)       shiftReg <= holdWord;
    else if (strb.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  assign serBit = shiftReg[WORD_W-1];
endmodule

// File: rtl/frame_serial_port.sv
module frame_serial_port
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RATIO  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              oeN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  output logic              sdo,
  output logic              sclk,
  output logic              frameN,
  output logic              outEn
);
  fsp_strobe_t strb;
  logic        pendValid;
  logic        txActive;
  logic        serBit;
  fsp_mode_e   modeSel;

  assign modeSel = fsp_mode_e'(mode);

  fsp_ctrl #(.WORD_W(WORD_W), .RATIO(RATIO)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .oeN(oeN),
    .pendValid(pendValid), .strb(strb), .bitClk(sclk), .txActive(txActive)
  );

  fsp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .strb(strb), .pendValid(pendValid), .serBit(serBit)
  );

  assign frameN = !txActive;
  assign sdo    = txActive ? serBit : 1'b0;
  assign outEn  = !oeN;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic oeN,
  input logic sdo,
  input logic sclk,
  input logic frameN
);
  localparam int CNT_W = $clog2(2 * WORD_W + 1) + 1;
  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN || frameN) lowCnt <= '0;
    else                 lowCnt <= lowCnt + 1'b1;
  end

  // R2: bit clock toggles on each master edge out of reset
  a_r2_sclk_toggles: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (sclk != $past(sclk)));

  // R4: frame falls together with a bit clock rising edge
  a_r4_frame_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> sclk);

  // R4: frame never stays low beyond 2*WORD_W master clocks
  a_r4_frame_length: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> (lowCnt < CNT_W'(2 * WORD_W)));

  // R5: data holds across the falling edge inside a frame
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclk) && !frameN && !$past(frameN)) |-> $stable(sdo));

  // R8: raising the enable input ends the transfer
  a_r8_abort_drops: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && oeN) |=> frameN);
endmodule

bind frame_serial_port fsp_checker #(.WORD_W(WORD_W)) u_fsp_checker (
  .clk(clk), .rstN(rstN), .oeN(oeN), .sdo(sdo), .sclk(sclk), .frameN(frameN)
);

// File: tb/frame_serial_port_bench.sv
module frame_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PER_STD = 256;
  localparam int PER_LOW = 512;
  localparam int NVEC = 4;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 16'h8001}, {2'd0, 16'h7FFE}, {2'd1, 16'hA5C3}, {2'd3, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        oeN = 1'b0;
  logic [15:0] wordIn = '0;
  logic        wordValid = 1'b0;
  logic        sdo, sclk, frameN, outEn;
  int          n = 0;
  int          tests = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  frame_serial_port u_frame_serial_port (
    .clk(clk), .rstN(rstN), .mode(mode), .oeN(oeN), .wordIn(wordIn),
    .wordValid(wordValid), .sdo(sdo), .sclk(sclk), .frameN(frameN), .outEn(outEn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // phase model: direct-mode reset clears it, otherwise it counts edges
  always @(posedge clk) begin
    if (!rstN && mode == 2'd0) n <= 0;
    else                       n <= n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (phase count %0d)", req, act, exp, n);
    end
  endtask

  task automatic waitPh(input int p, input int per);
    @(negedge clk);
    while ((n % per) != p) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    wordIn = w;
    wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic checkFrame(input logic [15:0] w, input int per, input string req);
    waitPh(2, per);
    check(frameN == 1'b1, req, frameN, 1);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check({frameN, sclk, sdo} == {2'b01, w[15-k]}, req, {frameN, sclk, sdo}, {2'b01, w[15-k]});
      @(negedge clk);
      check({frameN, sclk, sdo} == {2'b00, w[15-k]}, req, {frameN, sclk, sdo}, {2'b00, w[15-k]});
    end
    @(negedge clk);
    check(frameN == 1'b1, req, frameN, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 / R2: reset state in direct mode
    repeat (5) @(negedge clk);
    check(frameN == 1'b1, "R1", frameN, 1);
    check(sclk == 1'b0, "R2", sclk, 0);
    check(outEn == 1'b1, "R8", outEn, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R2", sclk, 1);
    @(negedge clk);
    check(sclk == 1'b0, "R2", sclk, 0);

    // R3 R4 R5 R6: vector table walk
    for (int i = 0; i < NVEC; i++) begin
      mode = VEC[i][17:16];
      waitPh(100, PER_STD);
      sendWord(VEC[i][15:0]);
      checkFrame(VEC[i][15:0], PER_STD, "R5");
    end
    mode = 2'd0;

    // R7: nothing pending -> no frame
    waitPh(3, PER_STD);
    check(frameN == 1'b1, "R7", frameN, 1);

    // R6: newer word overwrites waiting one
    waitPh(100, PER_STD);
    sendWord(16'h1111);
    waitPh(120, PER_STD);
    sendWord(16'hC0DE);
    checkFrame(16'hC0DE, PER_STD, "R6");

    // R6: word arriving mid-transfer waits
    waitPh(100, PER_STD);
    sendWord(16'h4321);
    fork
      checkFrame(16'h4321, PER_STD, "R6");
      begin waitPh(10, PER_STD); sendWord(16'h9ABC); end
    join
    checkFrame(16'h9ABC, PER_STD, "R6");

    // R8: abort mid-word
    waitPh(100, PER_STD);
    sendWord(16'hFFFF);
    waitPh(11, PER_STD);
    check(frameN == 1'b0, "R8", frameN, 0);
    oeN = 1'b1;
    #1;
    check(outEn == 1'b0, "R8", outEn, 0);
    waitPh(13, PER_STD);
    oeN = 1'b0;
    for (int p = 14; p <= 36; p++) begin
      @(negedge clk);
      check(frameN == 1'b1, "R8", frameN, 1);
    end

    // R8: pending word kept while disabled at frame start
    waitPh(100, PER_STD);
    sendWord(16'h1234);
    waitPh(1, PER_STD);
    oeN = 1'b1;
    waitPh(10, PER_STD);
    oeN = 1'b0;
    @(negedge clk);
    check(frameN == 1'b1, "R8", frameN, 1);
    checkFrame(16'h1234, PER_STD, "R8");

    // R9: direct-mode reset realigns the cadence
    waitPh(77, PER_STD);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(frameN == 1'b1, "R1", frameN, 1);
    check(sclk == 1'b0, "R9", sclk, 0);
    rstN = 1'b1;
    waitPh(100, PER_STD);
    sendWord(16'h0F0F);
    checkFrame(16'h0F0F, PER_STD, "R9");

    // R9 / R1: reset in 2x mode keeps cadence, clears pending
    mode = 2'd1;
    waitPh(40, PER_STD);
    sendWord(16'h5555);
    waitPh(50, PER_STD);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(frameN == 1'b1, "R1", frameN, 1);
    rstN = 1'b1;
    waitPh(3, PER_STD);
    check(frameN == 1'b1, "R1", frameN, 1);
    waitPh(100, PER_STD);
    sendWord(16'hBEEF);
    checkFrame(16'hBEEF, PER_STD, "R9");

    // R3: low-rate cadence after a fresh direct reset
    mode = 2'd0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mode = 2'd2;
    waitPh(100, PER_LOW);
    sendWord(16'h8000);
    checkFrame(16'h8000, PER_LOW, "R3");
    waitPh(100, PER_LOW);
    sendWord(16'h0001);
    waitPh(150, PER_LOW);
    sendWord(16'h6A6A);
    waitPh(259, PER_LOW);
    check(frameN == 1'b1, "R3", frameN, 1);
    checkFrame(16'h6A6A, PER_LOW, "R3");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule